// File: doc/BRIEF.md
# Folding Fetch Unit with Pre-decoded Instruction Cache

This unit is the fetch stage of a simple in-order pipeline. It keeps a small direct-mapped cache in which every entry holds one instruction together with the address that fetch must go to next. When an entry is filled from instruction memory, the word that follows the filled instruction is examined. If that following word is an unconditional jump, a jump-and-link or a conditional branch, it is taken out of the stream. Its target goes into the next-address field of the entry being filled. Because of this, jumps cost no fetch cycle at all, and conditional branches are predicted taken at no cost.

Each cycle the unit presents the instruction at the current fetch address, that address, and the stored successor address. A folded jump-and-link also produces a return address. The link write has no instruction slot of its own, so the unit holds fetch and raises a stall flag whenever that write would collide with another writeback. Execute reports the outcome of a folded branch one cycle after the branch entry is delivered. On a not-taken outcome the unit marks the instruction fetched in that cycle as squashed, and fetch moves to the fall-through address at the next clock edge. On a miss, the unit requests a two-word line from the backing memory and waits for it.

Top module: `fold_fetch`

## Requirements
- R1: When reset is released, `f_valid` is low, `f_pc` equals the reset vector (0x0100) and `mem_req` is low. Every cache entry is invalid, so the first fetch of any address starts a fill, including an address that was cached before the reset.
- R2: On a miss, `mem_req` rises one cycle later with `mem_addr` equal to the missing address. It stays high with a stable address until `mem_rvalid`. `mem_rdata` carries the word at the address in bits [31:0] and the word at address+4 in bits [63:32]. No instruction is delivered while a fill is outstanding.
- R3: For an entry that is not folded, `f_next` equals its own address plus 4, and `f_instr` equals the memory word at `f_pc`.
- R4: Opcodes sit in bits [31:26]. The value 0x02 is a jump and its target is bits [13:0] shifted left by 2. When a jump follows an instruction that is not a control transfer, the jump address is never delivered. The preceding entry carries the target in `f_next`, and once the cache is warm the target is delivered in the very next cycle.
- R5: Opcode 0x03 is jump-and-link. When it is folded, the preceding entry is delivered with `link_valid` high and `link_pc` equal to the jump's own address plus 4. That is the preceding instruction's address plus 8.
- R6: Opcode 0x04 is a conditional branch. When it is folded, it is predicted taken: `f_next` is the branch target, and the target is fetched in the following cycle.
- R7: When `res_valid` is high and `res_taken` is low, `squash` is high in that same cycle. In the next cycle `f_pc` is the branch's own address plus 4.
- R8: A taken resolution causes no squash, and fetch carries on from the target without a lost cycle.
- R9: When a folded jump-and-link entry is hit while `wb_busy` is high, `wr_stall` is high, `f_valid` is low and `f_pc` holds until `wb_busy` falls.
- R10: A jump or jump-and-link at an address that is itself fetched (the preceding word was not folded with it) is delivered as an instruction with `f_next` equal to its target. For a jump-and-link, `link_pc` is its own address plus 4 and `wb_busy` causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req | output | 1 | Line fill request, held until the response |
| mem_addr | output | 16 | Address of the first word of the requested line |
| mem_rvalid | input | 1 | Fill data valid, one cycle |
| mem_rdata | input | 64 | Two instruction words, the lower address in the low half |
| res_valid | input | 1 | Folded branch outcome available |
| res_taken | input | 1 | Folded branch was taken |
| wb_busy | input | 1 | Another writeback occupies the register write port |
| f_valid | output | 1 | An instruction is delivered this cycle |
| f_pc | output | 16 | Current fetch address |
| f_instr | output | 32 | Delivered instruction word |
| f_next | output | 16 | Stored successor address of the delivered entry |
| link_valid | output | 1 | Delivered entry carries a return address |
| link_pc | output | 16 | Return address for jump-and-link |
| squash | output | 1 | Instruction fetched this cycle is discarded |
| wr_stall | output | 1 | Fetch held by a link-write collision |

## Verification
The assertions assume that execute raises `res_valid` only in the cycle right after a folded branch entry was delivered. They also assume that memory answers each request with exactly one `mem_rvalid` pulse while `mem_req` is high. The bench's execute model derives `res_valid` from the previous cycle's delivered address of the known branch entry. Its memory model raises one response after a fixed latency and then waits for the request to drop. Stall tests change `wb_busy` only between cycles and never together with a branch resolution, so the squash and hold properties never overlap.

// File: rtl/fold_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the folding fetch unit: opcode values recognised
// during pre-decode and the kind of fold recorded in each cache entry.
package fold_pkg;

    localparam int unsigned OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_JUMP   = 6'h02;
    localparam logic [OPC_W-1:0] OPC_LINK   = 6'h03;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 6'h04;

    // How an entry's successor address was formed
    typedef enum logic [2:0] {
        FK_PLAIN,     // sequential, or an unfolded jump that names its own target
        FK_JMP,       // following jump folded in
        FK_JAL,       // following jump-and-link folded in, link write pending
        FK_BR,        // following conditional branch folded in, predicted taken
        FK_SELF_JAL   // entry is itself an unfolded jump-and-link
    } fold_kind_e;

    // True when an opcode transfers control
    function automatic logic is_ctl(input logic [OPC_W-1:0] opc);
        return (opc == OPC_JUMP) || (opc == OPC_LINK) || (opc == OPC_BRANCH);
    endfunction

endpackage

// File: rtl/fold_predecode.sv
`timescale 1ns/1ps
// Pre-decoder: turns a two-word line into one cache entry for the lower word.
// Assumes opcodes in the top six bits and absolute word targets in the low
// ADDR_W-2 bits. Only the lower word is ever stored; the upper word is looked
// at solely to fold a following control transfer into the lower entry.
module fold_predecode
    import fold_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned INSTR_W = 32
) (
    input  logic [ADDR_W-1:0]  line_addr,
    input  logic [INSTR_W-1:0] word_lo,
    input  logic [INSTR_W-1:0] word_hi,
    output logic [INSTR_W-1:0] ent_instr,
    output logic [ADDR_W-1:0]  ent_next,
    output fold_kind_e         ent_kind
);

    logic [OPC_W-1:0]  opc_lo, opc_hi;
    logic [ADDR_W-1:0] tgt_lo, tgt_hi, seq_addr;
    logic              hi_unused;

    assign opc_lo    = word_lo[INSTR_W-1 -: OPC_W];
    assign opc_hi    = word_hi[INSTR_W-1 -: OPC_W];
    assign tgt_lo    = {word_lo[ADDR_W-3:0], 2'b00};
    assign tgt_hi    = {word_hi[ADDR_W-3:0], 2'b00};
    assign seq_addr  = line_addr + ADDR_W'(4);
    assign hi_unused = ^word_hi[INSTR_W-OPC_W-1:ADDR_W-2];

    // Pick the successor address and fold kind for the lower word
    always_comb begin
        ent_instr = word_lo;
        ent_next  = seq_addr;
        ent_kind  = FK_PLAIN;
        if (opc_lo == OPC_JUMP) begin
            ent_next = tgt_lo;
        end else if (opc_lo == OPC_LINK) begin
            ent_next = tgt_lo;
            ent_kind = FK_SELF_JAL;
        end else if (!is_ctl(opc_lo)) begin
            unique case (opc_hi)
                OPC_JUMP:   begin ent_next = tgt_hi; ent_kind = FK_JMP; end
                OPC_LINK:   begin ent_next = tgt_hi; ent_kind = FK_JAL; end
                OPC_BRANCH: begin ent_next = tgt_hi; ent_kind = FK_BR;  end
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/fold_cache.sv
`timescale 1ns/1ps
// Direct-mapped store of pre-decoded entries, one per instruction word.
// Assumes word-aligned addresses; read is combinational, write on the edge.
// Valid bits clear on reset; the data arrays need no reset.
module fold_cache
    import fold_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned SETS    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic               rd_hit,
    output logic [INSTR_W-1:0] rd_instr,
    output logic [ADDR_W-1:0]  rd_next,
    output fold_kind_e         rd_kind,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [INSTR_W-1:0] wr_instr,
    input  logic [ADDR_W-1:0]  wr_next,
    input  fold_kind_e         wr_kind
);

    localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int unsigned TAG_W = ADDR_W - 2 - IDX_W;

    logic [SETS-1:0]    valid_q;
    logic [TAG_W-1:0]   tag_q   [SETS];
    logic [INSTR_W-1:0] instr_q [SETS];
    logic [ADDR_W-1:0]  next_q  [SETS];
    fold_kind_e         kind_q  [SETS];

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;
    logic             low_bits_unused;

    assign rd_idx          = rd_addr[IDX_W+1:2];
    assign wr_idx          = wr_addr[IDX_W+1:2];
    assign rd_tag          = rd_addr[ADDR_W-1:IDX_W+2];
    assign wr_tag          = wr_addr[ADDR_W-1:IDX_W+2];
    assign low_bits_unused = ^{rd_addr[1:0], wr_addr[1:0]};

    // Valid bits: all cleared by reset, set when an entry is written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Entry payload written from the pre-decoder
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]   <= wr_tag;
            instr_q[wr_idx] <= wr_instr;
            next_q[wr_idx]  <= wr_next;
            kind_q[wr_idx]  <= wr_kind;
        end
    end

    // Lookup at the fetch address
    always_comb begin
        rd_hit   = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_instr = instr_q[rd_idx];
        rd_next  = next_q[rd_idx];
        rd_kind  = kind_q[rd_idx];
    end

endmodule

// File: rtl/fold_refill.sv
`timescale 1ns/1ps
// Miss handler: latches the missing address, holds a request to the backing
// memory until the single response beat arrives, then flags the write.
// Assumes memory answers each request with one mem_rvalid pulse.
module fold_refill #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              mem_rvalid,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              fill_done
);

    typedef enum logic {RF_IDLE, RF_WAIT} rf_state_e;

    rf_state_e         state_q;
    logic [ADDR_W-1:0] addr_q;

    // Request state machine: idle until a miss, wait until data returns
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RF_IDLE;
            addr_q  <= '0;
        end else begin
            unique case (state_q)
                RF_IDLE: if (start) begin
                    state_q <= RF_WAIT;
                    addr_q  <= start_addr;
                end
                RF_WAIT: if (mem_rvalid) state_q <= RF_IDLE;
                default: state_q <= RF_IDLE;
            endcase
        end
    end

    assign busy      = (state_q == RF_WAIT);
    assign mem_req   = busy;
    assign mem_addr  = addr_q;
    assign fill_done = busy && mem_rvalid;

    AST_REQ_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R2

endmodule

// File: rtl/fold_fetch.sv
`timescale 1ns/1ps
// Folding fetch unit (top). Fetch address advances from the stored successor
// field of each cache entry; there is no next-address incrementer on the hit
// path. Assumes execute resolves a folded branch exactly one cycle after its
// entry is delivered, and that the link write of a folded jump-and-link must
// not share a cycle with another writeback.
module fold_fetch
    import fold_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned INSTR_W   = 32,
    parameter int unsigned SETS      = 8,
    parameter int unsigned RESET_VEC = 'h0100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_rvalid,
    input  logic [2*INSTR_W-1:0] mem_rdata,
    input  logic                 res_valid,
    input  logic                 res_taken,
    input  logic                 wb_busy,
    output logic                 f_valid,
    output logic [ADDR_W-1:0]    f_pc,
    output logic [INSTR_W-1:0]   f_instr,
    output logic [ADDR_W-1:0]    f_next,
    output logic                 link_valid,
    output logic [ADDR_W-1:0]    link_pc,
    output logic                 squash,
    output logic                 wr_stall
);

    localparam logic [ADDR_W-1:0] VEC = ADDR_W'(RESET_VEC);

    logic [ADDR_W-1:0]  pc_q, fall_q, pc_d;
    logic               br_last_q;
    logic               hit, busy, fill_done, start, deliver, redirect;
    logic [INSTR_W-1:0] hit_instr, pd_instr;
    logic [ADDR_W-1:0]  hit_next, pd_next;
    fold_kind_e         hit_kind, pd_kind;

    fold_refill #(.ADDR_W(ADDR_W)) u_refill (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (pc_q),
        .mem_rvalid (mem_rvalid),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .fill_done  (fill_done)
    );

    fold_predecode #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_predecode (
        .line_addr (mem_addr),
        .word_lo   (mem_rdata[INSTR_W-1:0]),
        .word_hi   (mem_rdata[2*INSTR_W-1:INSTR_W]),
        .ent_instr (pd_instr),
        .ent_next  (pd_next),
        .ent_kind  (pd_kind)
    );

    fold_cache #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .SETS(SETS)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (pc_q),
        .rd_hit   (hit),
        .rd_instr (hit_instr),
        .rd_next  (hit_next),
        .rd_kind  (hit_kind),
        .wr_en    (fill_done),
        .wr_addr  (mem_addr),
        .wr_instr (pd_instr),
        .wr_next  (pd_next),
        .wr_kind  (pd_kind)
    );

    // Delivery, stall, squash and next fetch address for this cycle
    always_comb begin
        wr_stall = hit && !busy && (hit_kind == FK_JAL) && wb_busy;
        deliver  = hit && !busy && !wr_stall;
        redirect = res_valid && !res_taken;
        start    = !hit && !busy;
        if (redirect)     pc_d = fall_q;
        else if (deliver) pc_d = hit_next;
        else              pc_d = pc_q;
    end

    // Output port view of the lookup
    always_comb begin
        f_valid    = deliver;
        f_pc       = pc_q;
        f_instr    = hit_instr;
        f_next     = hit_next;
        squash     = redirect;
        link_valid = deliver && ((hit_kind == FK_JAL) || (hit_kind == FK_SELF_JAL));
        link_pc    = (hit_kind == FK_JAL) ? pc_q + ADDR_W'(8) : pc_q + ADDR_W'(4);
    end

    // Fetch address register and the fall-through of the last folded branch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= VEC;
            fall_q    <= VEC;
            br_last_q <= 1'b0;
        end else begin
            pc_q      <= pc_d;
            br_last_q <= deliver && (hit_kind == FK_BR);
            if (deliver && (hit_kind == FK_BR)) fall_q <= pc_q + ADDR_W'(8);
        end
    end

    AST_RESOLVE_AFTER_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> br_last_q); // R7

    AST_SQUASH_TO_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (f_pc == $past(f_pc, 2) + ADDR_W'(8))); // R7

    AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stall && !squash) |=> $stable(f_pc)); // R9

    AST_NO_DELIVER_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        f_valid |-> !mem_req); // R2

endmodule

// File: tb/fold_fetch_test.sv
`timescale 1ns/1ps
// Directed bench for the folding fetch unit.
module fold_fetch_test;

    localparam int MEM_LAT = 2;
    localparam logic [5:0] OP_J = 6'h02, OP_L = 6'h03, OP_B = 6'h04;

    logic        clk, rst_n;
    logic        mem_req, mem_rvalid;
    logic [15:0] mem_addr;
    logic [63:0] mem_rdata;
    logic        res_valid, res_taken, wb_busy;
    logic        f_valid, link_valid, squash, wr_stall;
    logic [15:0] f_pc, f_next, link_pc;
    logic [31:0] f_instr;

    logic [31:0] imem [256];

    int checks = 0, fails = 0;
    int rec_n, cyc, sq_first, sq_vis, ws_n, br_seen, taken_limit;
    logic prev_br, br_enable;
    logic [15:0] br_pc;
    logic [15:0] rec_pc [64];
    logic [15:0] rec_next [64];
    logic [31:0] rec_instr [64];
    logic        rec_lv [64];
    logic [15:0] rec_lp [64];
    int          rec_cyc [64];

    fold_fetch uut (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .res_valid(res_valid),
        .res_taken(res_taken), .wb_busy(wb_busy), .f_valid(f_valid), .f_pc(f_pc),
        .f_instr(f_instr), .f_next(f_next), .link_valid(link_valid),
        .link_pc(link_pc), .squash(squash), .wr_stall(wr_stall)
    );

    initial begin
        clk = 1'b0;
        forever #10 clk = ~clk;
    end

    // Backing memory: one response beat MEM_LAT cycles after a request
    initial begin
        int lat;
        logic [7:0] ia;
        lat = 0;
        mem_rvalid = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (!rst_n || mem_rvalid) begin
                mem_rvalid = 1'b0;
                lat = 0;
            end else if (mem_req) begin
                if (lat == MEM_LAT) begin
                    ia = mem_addr[9:2];
                    mem_rdata = {imem[ia + 8'd1], imem[ia]};
                    mem_rvalid = 1'b1;
                end else begin
                    lat++;
                end
            end else begin
                lat = 0;
            end
        end
    end

    function automatic logic [31:0] plain(input int n);
        return {6'h00, 26'(n + 'h1000)};
    endfunction

    function automatic logic [31:0] ctl(input logic [5:0] op, input logic [15:0] t);
        return {op, 12'b0, t[15:2]};
    endfunction

    function automatic logic [7:0] wi(input logic [15:0] a);
        return a[9:2];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) imem[i] = plain(i);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        res_valid = 1'b0;
        res_taken = 1'b0;
        wb_busy = 1'b0;
        rec_n = 0; cyc = 0; sq_first = -1; sq_vis = 0; ws_n = 0;
        br_seen = 0; prev_br = 1'b0; br_enable = 1'b0; taken_limit = 0;
        br_pc = 16'h0100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Run n cycles, playing execute for the folded branch and recording deliveries
    task automatic step_trace(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            res_valid = prev_br;
            res_taken = (br_seen < taken_limit);
            if (prev_br) br_seen++;
            #1;
            if (wr_stall) ws_n++;
            if (squash) begin
                if (sq_first < 0) sq_first = cyc;
                if (f_valid && f_pc == 16'h0110) sq_vis++;
            end
            if (f_valid && !squash && rec_n < 64) begin
                rec_pc[rec_n] = f_pc;
                rec_next[rec_n] = f_next;
                rec_instr[rec_n] = f_instr;
                rec_lv[rec_n] = link_valid;
                rec_lp[rec_n] = link_pc;
                rec_cyc[rec_n] = cyc;
                rec_n++;
            end
            prev_br = br_enable && f_valid && !squash && (f_pc == br_pc);
            cyc++;
        end
        @(negedge clk);
        res_valid = 1'b0;
        prev_br = 1'b0;
    endtask

    // Reset state and first miss request
    task automatic t_reset_state();
        clear_mem();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R1", "f_valid in reset", f_valid, 0);
        chk("R1", "f_pc in reset", f_pc, 16'h0100);
        chk("R1", "mem_req in reset", mem_req, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R2", "miss f_valid", f_valid, 0);
        @(negedge clk);
        #1;
        chk("R2", "mem_req after miss", mem_req, 1);
        chk("R2", "mem_addr after miss", mem_addr, 16'h0100);
    endtask

    // Jump folding and sequential entries
    task automatic t_jump_fold();
        bit seen_jump;
        clear_mem();
        imem[wi(16'h0108)] = ctl(OP_J, 16'h0110);
        imem[wi(16'h0118)] = ctl(OP_J, 16'h0100);
        do_reset();
        step_trace(60);
        chk("R4", "delivery count", rec_n >= 8, 1);
        chk("R4", "seq[0]", rec_pc[0], 16'h0100);
        chk("R4", "seq[1]", rec_pc[1], 16'h0104);
        chk("R4", "seq[2]", rec_pc[2], 16'h0110);
        chk("R4", "seq[3]", rec_pc[3], 16'h0114);
        chk("R4", "seq[4]", rec_pc[4], 16'h0100);
        chk("R4", "seq[6]", rec_pc[6], 16'h0110);
        chk("R3", "plain next", rec_next[0], 16'h0104);
        chk("R3", "instr word", rec_instr[0], imem[wi(16'h0100)]);
        chk("R4", "folded next", rec_next[1], 16'h0110);
        chk("R4", "warm jump gap", rec_cyc[6] - rec_cyc[5], 1);
        seen_jump = 1'b0;
        for (int i = 0; i < rec_n; i++)
            if (rec_pc[i] == 16'h0108 || rec_pc[i] == 16'h0118) seen_jump = 1'b1;
        chk("R4", "jump never delivered", seen_jump, 0);
    endtask

    // Folded jump-and-link: return address and write-conflict stall
    task automatic t_link_fold();
        bit seen;
        clear_mem();
        imem[wi(16'h0104)] = ctl(OP_L, 16'h0110);
        imem[wi(16'h0114)] = ctl(OP_J, 16'h0100);
        do_reset();
        step_trace(40);
        chk("R5", "seq[0]", rec_pc[0], 16'h0100);
        chk("R5", "seq[1]", rec_pc[1], 16'h0110);
        chk("R5", "link_valid", rec_lv[0], 1);
        chk("R5", "link_pc", rec_lp[0], 16'h0108);
        chk("R5", "no link on plain", rec_lv[1], 0);
        seen = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            @(negedge clk);
            #1;
            if (f_valid && f_pc == 16'h0110) seen = 1'b1;
        end
        @(negedge clk);
        wb_busy = 1'b1;
        #1;
        chk("R9", "wr_stall raised", wr_stall, 1);
        chk("R9", "no delivery in stall", f_valid, 0);
        chk("R9", "pc at link entry", f_pc, 16'h0100);
        repeat (3) @(negedge clk);
        #1;
        chk("R9", "still stalled", wr_stall, 1);
        chk("R9", "pc held", f_pc, 16'h0100);
        @(negedge clk);
        wb_busy = 1'b0;
        #1;
        chk("R9", "released delivery", f_valid, 1);
        chk("R9", "released pc", f_pc, 16'h0100);
        chk("R9", "released link_pc", link_pc, 16'h0108);
    endtask

    // Folded branch: two taken, then not taken
    task automatic t_branch_fold();
        clear_mem();
        imem[wi(16'h0104)] = ctl(OP_B, 16'h0110);
        imem[wi(16'h010C)] = ctl(OP_J, 16'h0100);
        imem[wi(16'h0114)] = ctl(OP_J, 16'h0100);
        do_reset();
        br_enable = 1'b1;
        taken_limit = 2;
        step_trace(80);
        chk("R6", "branch entry next", rec_next[0], 16'h0110);
        chk("R6", "seq[1]", rec_pc[1], 16'h0110);
        chk("R8", "seq[3]", rec_pc[3], 16'h0110);
        chk("R8", "warm taken gap", rec_cyc[3] - rec_cyc[2], 1);
        chk("R8", "no squash while taken", sq_first > rec_cyc[3], 1);
        chk("R7", "fallthrough seq[5]", rec_pc[5], 16'h0108);
        chk("R7", "seq[6]", rec_pc[6], 16'h0100);
        chk("R7", "fallthrough seq[7]", rec_pc[7], 16'h0108);
        chk("R7", "delivered target squashed", sq_vis > 0, 1);
        chk("R7", "warm redirect gap", rec_cyc[7] - rec_cyc[6], 2);
    endtask

    // Unfolded jump-and-link at a fetched address; then reset clears the cache
    task automatic t_unfolded();
        clear_mem();
        imem[wi(16'h0100)] = ctl(OP_L, 16'h0110);
        imem[wi(16'h0114)] = ctl(OP_J, 16'h0100);
        do_reset();
        wb_busy = 1'b1;
        step_trace(40);
        wb_busy = 1'b0;
        chk("R10", "seq[0]", rec_pc[0], 16'h0100);
        chk("R10", "seq[1]", rec_pc[1], 16'h0110);
        chk("R10", "seq[2]", rec_pc[2], 16'h0100);
        chk("R10", "next is target", rec_next[0], 16'h0110);
        chk("R10", "link_valid", rec_lv[0], 1);
        chk("R10", "link_pc", rec_lp[0], 16'h0104);
        chk("R10", "wb_busy ignored", ws_n, 0);
        do_reset();
        #1;
        chk("R1", "entries invalid after reset", f_valid, 0);
        @(negedge clk);
        #1;
        chk("R1", "refetch after reset", mem_req, 1);
        chk("R1", "refetch addr", mem_addr, 16'h0100);
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        res_valid = 1'b0;
        res_taken = 1'b0;
        wb_busy = 1'b0;
        br_enable = 1'b0;
        prev_br = 1'b0;
        clear_mem();
        t_reset_state();
        t_jump_fold();
        t_link_fold();
        t_branch_fold();
        t_unfolded();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule